// File: doc/BRIEF.md
# Mode-Gated Shared Interrupt Controller

This block gathers the event lines of a packet radio into one interrupt pin. The events come in three groups: transmit, receive and system. Each event line has a sticky status bit and an enable bit. The pin asserts while any source has both its status bit and its enable bit set, unless the radio's current mode blocks that source's group. While transmitting, the receive group is blocked. While receiving, the transmit group is blocked. The system group is never blocked. Blocking is applied after the enable registers, so the stored enable values survive every mode change.

A small register port exposes the enables, the status bits and a configuration register. Software can poll the status registers even for sources it has disabled, and reading a status register clears it. The configuration register sets the pin's asserted level and chooses between push-pull drive and open-drain drive. In open-drain mode the pin is released to high impedance when no interrupt is pending.

The radio mode is tracked by a three-state machine with the states MODE_IDLE, MODE_TX and MODE_RX. On every clock the request code selects the target state. From any state, request 00 moves to MODE_IDLE, 01 moves to MODE_TX and 10 moves to MODE_RX. Request 11 keeps the current state. MODE_IDLE blocks no group, MODE_TX blocks the receive group, and MODE_RX blocks the transmit group.

Top module: `radio_irq_ctrl`

## Requirements
- R1: A one-cycle event pulse sets its status bit at the next clock edge, whether the source is enabled or not. Status can be read at address 3 (transmit), 4 (receive) or 5 (system), with source i in bit i and the unused upper bits reading 0.
- R2: Reading a status register (reg_rd_i high with its address) returns the current bits in the same cycle and clears them at that clock edge. A bit whose event arrives in the same cycle as the read stays set.
- R3: Writes to the status addresses have no effect.
- R4: The enable registers are at address 0 (transmit), 1 (receive) and 2 (system), bit i for source i. They can be written and read back, and the bits above the group width read 0.
- R5: The pin state is registered. It changes one clock edge after the status, enable or mode state that causes the change.
- R6: In MODE_TX, receive sources cannot assert the pin. In MODE_RX, transmit sources cannot assert the pin. In MODE_IDLE no group is blocked. System sources are never blocked.
- R7: Mode changes never alter the stored enable bits.
- R8: The mode request is sampled on each clock edge: 00 selects idle, 01 transmit, 10 receive, and 11 holds the current mode.
- R9: The configuration register is at address 6. Bit 0 set means the pin is active high; bit 0 clear means active low.
- R10: Bit 1 of the configuration register selects push-pull drive (1) or open-drain drive (0).
  - In push-pull mode, irq_oe_o is always 1 and irq_o shows the asserted or deasserted level.
  - In open-drain mode, irq_o always carries the asserted level and irq_oe_o is 1 only while an interrupt is pending.
- R11: Reset clears every status, enable and configuration bit (active low, open drain) and sets the mode to idle. The pin comes out of reset with irq_o=0 and irq_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_i | input | 2 | Radio mode request: 00 idle, 01 transmit, 10 receive, 11 hold |
| tx_evt_i | input | TX_W | Transmit event pulses |
| rx_evt_i | input | RX_W | Receive event pulses |
| sys_evt_i | input | SYS_W | System event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status registers) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the cycle of reg_rd_i |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The hardest situation to reach is an event that arrives while its group is blocked and only reaches the pin later. To get there, the bench enables the source, places the block in the mode that blocks it, and pulses the event. It then shows the pin stays quiet while status already holds the bit. Next it moves the mode to idle and expects the pin to assert one edge later, with no new event. A second hard case is a read that lands in the same cycle as a new event on the bit being read. The bench drives the read strobe and the event pulse together, then reads twice more to show that the bit survived the first clear and goes away on the second.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    // Mode request codes; 2'b11 holds the present mode
    localparam logic [1:0] REQ_IDLE = 2'b00;
    localparam logic [1:0] REQ_TX   = 2'b01;
    localparam logic [1:0] REQ_RX   = 2'b10;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10
    } radio_mode_e;

    localparam logic [REG_AW-1:0] A_TX_EN  = 3'd0;
    localparam logic [REG_AW-1:0] A_RX_EN  = 3'd1;
    localparam logic [REG_AW-1:0] A_SYS_EN = 3'd2;
    localparam logic [REG_AW-1:0] A_TX_ST  = 3'd3;
    localparam logic [REG_AW-1:0] A_RX_ST  = 3'd4;
    localparam logic [REG_AW-1:0] A_SYS_ST = 3'd5;
    localparam logic [REG_AW-1:0] A_CFG    = 3'd6;

    localparam int CFG_POL_BIT = 0;
    localparam int CFG_PP_BIT  = 1;

endpackage

// File: rtl/irq_src_bank.sv
// One group of event sources: enable register plus sticky status bits.
module irq_src_bank
    import irq_ctrl_pkg::*;
#(
    parameter int                W       = 4,
    parameter logic [REG_AW-1:0] EN_ADDR = A_TX_EN,
    parameter logic [REG_AW-1:0] ST_ADDR = A_TX_ST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      stat_o,
    output logic [REG_DW-1:0] rdata_o
);

    logic en_wr;
    logic st_rd;

    assign en_wr = wr_i && (addr_i == EN_ADDR);
    assign st_rd = rd_i && (addr_i == ST_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (en_wr) begin
            en_o <= wdata_i[W-1:0];
        end
    end

    // Sticky status flops: a new event beats a clearing read
    for (genvar i = 0; i < W; i++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_o[i] <= 1'b0;
            end else if (evt_i[i]) begin
                stat_o[i] <= 1'b1;
            end else if (st_rd) begin
                stat_o[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i && (addr_i == EN_ADDR)) begin
            rdata_o[W-1:0] = en_o;
        end else if (st_rd) begin
            rdata_o[W-1:0] = stat_o;
        end
    end

endmodule

// File: rtl/irq_mode_fsm.sv
// Tracks the radio mode and derives the per-group pass gates.
module irq_mode_fsm
    import irq_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_req_i,
    output radio_mode_e mode_o,
    output logic        tx_pass_o,
    output logic        rx_pass_o
);

    radio_mode_e state_q;
    radio_mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_IDLE: begin
                if (mode_req_i == REQ_TX)      state_d = MODE_TX;
                else if (mode_req_i == REQ_RX) state_d = MODE_RX;
            end
            MODE_TX: begin
                if (mode_req_i == REQ_IDLE)    state_d = MODE_IDLE;
                else if (mode_req_i == REQ_RX) state_d = MODE_RX;
            end
            MODE_RX: begin
                if (mode_req_i == REQ_IDLE)    state_d = MODE_IDLE;
                else if (mode_req_i == REQ_TX) state_d = MODE_TX;
            end
            default: state_d = MODE_IDLE;
        endcase
    end

    always_comb begin
        mode_o    = state_q;
        tx_pass_o = 1'b1;
        rx_pass_o = 1'b1;
        unique case (state_q)
            MODE_IDLE: begin
                tx_pass_o = 1'b1;
                rx_pass_o = 1'b1;
            end
            MODE_TX: rx_pass_o = 1'b0;
            MODE_RX: tx_pass_o = 1'b0;
            default: begin
                tx_pass_o = 1'b1;
                rx_pass_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/irq_pin_drv.sv
// Registered pin shaping: polarity and push-pull / open-drain drive.
module irq_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic act_high_i,
    input  logic push_pull_i,
    output logic pin_o,
    output logic pin_oe_o
);

    logic pin_d;
    logic oe_d;

    always_comb begin
        if (push_pull_i) begin
            pin_d = pend_i ? act_high_i : ~act_high_i;
            oe_d  = 1'b1;
        end else begin
            pin_d = act_high_i;
            oe_d  = pend_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_o    <= 1'b0;
            pin_oe_o <= 1'b0;
        end else begin
            pin_o    <= pin_d;
            pin_oe_o <= oe_d;
        end
    end

endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int TX_W  = 4,
    parameter int RX_W  = 4,
    parameter int SYS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_req_i,
    input  logic [TX_W-1:0]   tx_evt_i,
    input  logic [RX_W-1:0]   rx_evt_i,
    input  logic [SYS_W-1:0]  sys_evt_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              irq_oe_o
);

    logic [TX_W-1:0]   tx_en,  tx_stat;
    logic [RX_W-1:0]   rx_en,  rx_stat;
    logic [SYS_W-1:0]  sys_en, sys_stat;
    logic [REG_DW-1:0] tx_rd,  rx_rd, sys_rd, cfg_rd;
    logic              cfg_pol, cfg_pp;
    logic              tx_pass, rx_pass;
    logic              pend;
    radio_mode_e       mode_q;

    irq_src_bank #(.W(TX_W), .EN_ADDR(A_TX_EN), .ST_ADDR(A_TX_ST)) u_tx (
        .clk(clk), .rst_n(rst_n), .evt_i(tx_evt_i), .wr_i(reg_wr_i),
        .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .en_o(tx_en), .stat_o(tx_stat), .rdata_o(tx_rd)
    );

    irq_src_bank #(.W(RX_W), .EN_ADDR(A_RX_EN), .ST_ADDR(A_RX_ST)) u_rx (
        .clk(clk), .rst_n(rst_n), .evt_i(rx_evt_i), .wr_i(reg_wr_i),
        .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .en_o(rx_en), .stat_o(rx_stat), .rdata_o(rx_rd)
    );

    irq_src_bank #(.W(SYS_W), .EN_ADDR(A_SYS_EN), .ST_ADDR(A_SYS_ST)) u_sys (
        .clk(clk), .rst_n(rst_n), .evt_i(sys_evt_i), .wr_i(reg_wr_i),
        .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .en_o(sys_en), .stat_o(sys_stat), .rdata_o(sys_rd)
    );

    irq_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req_i),
        .mode_o(mode_q), .tx_pass_o(tx_pass), .rx_pass_o(rx_pass)
    );

    // Output configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_pol <= 1'b0;
            cfg_pp  <= 1'b0;
        end else if (reg_wr_i && (reg_addr_i == A_CFG)) begin
            cfg_pol <= reg_wdata_i[CFG_POL_BIT];
            cfg_pp  <= reg_wdata_i[CFG_PP_BIT];
        end
    end

    always_comb begin
        cfg_rd = '0;
        if (reg_rd_i && (reg_addr_i == A_CFG)) begin
            cfg_rd[CFG_POL_BIT] = cfg_pol;
            cfg_rd[CFG_PP_BIT]  = cfg_pp;
        end
    end

    assign reg_rdata_o = tx_rd | rx_rd | sys_rd | cfg_rd;

    // Mode gating sits after the enables; stored enables stay untouched
    assign pend = (tx_pass && |(tx_stat & tx_en))
                | (rx_pass && |(rx_stat & rx_en))
                | (|(sys_stat & sys_en));

    irq_pin_drv u_pin (
        .clk(clk), .rst_n(rst_n), .pend_i(pend),
        .act_high_i(cfg_pol), .push_pull_i(cfg_pp),
        .pin_o(irq_o), .pin_oe_o(irq_oe_o)
    );

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_ctrl_pkg::*;
#(
    parameter int TX_W  = 4,
    parameter int RX_W  = 4,
    parameter int SYS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [TX_W-1:0]   tx_evt_i,
    input logic [TX_W-1:0]   tx_en,
    input logic [RX_W-1:0]   rx_en,
    input logic [SYS_W-1:0]  sys_en,
    input logic [TX_W-1:0]   tx_stat,
    input logic [RX_W-1:0]   rx_stat,
    input logic [SYS_W-1:0]  sys_stat,
    input logic [1:0]        mode_q,
    input logic              cfg_pol,
    input logic              cfg_pp,
    input logic              irq_o,
    input logic              irq_oe_o
);

    logic pin_idle;
    assign pin_idle = cfg_pp ? (irq_oe_o && (irq_o != cfg_pol)) : !irq_oe_o;

    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_evt_i) |=> ((tx_stat & $past(tx_evt_i)) == $past(tx_evt_i))); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == A_TX_ST && tx_evt_i == '0) |=> (tx_stat == '0)); // R2

    AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable({tx_en, rx_en, sys_en})); // R7

    AST_TX_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TX && (tx_stat & tx_en) == '0 && (sys_stat & sys_en) == '0
         && !reg_wr_i) |=> pin_idle); // R6

    AST_RX_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RX && (rx_stat & rx_en) == '0 && (sys_stat & sys_en) == '0
         && !reg_wr_i) |=> pin_idle); // R6

    AST_PUSH_PULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pp |=> irq_oe_o); // R10

    AST_OPEN_DRAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pp |=> (irq_o == $past(cfg_pol))); // R9

endmodule

bind radio_irq_ctrl irq_ctrl_checker #(.TX_W(TX_W), .RX_W(RX_W), .SYS_W(SYS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .tx_evt_i(tx_evt_i), .tx_en(tx_en), .rx_en(rx_en),
    .sys_en(sys_en), .tx_stat(tx_stat), .rx_stat(rx_stat), .sys_stat(sys_stat),
    .mode_q(mode_q), .cfg_pol(cfg_pol), .cfg_pp(cfg_pp), .irq_o(irq_o),
    .irq_oe_o(irq_oe_o)
);

// File: tb/radio_irq_ctrl_test.sv
module radio_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic [3:0] tx_evt = '0, rx_evt = '0, sys_evt = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, irq_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_pol = 1'b0;
    bit m_pp  = 1'b0;

    always #4 clk = ~clk;

    radio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req), .tx_evt_i(tx_evt),
        .rx_evt_i(rx_evt), .sys_evt_i(sys_evt), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq), .irq_oe_o(irq_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        if (a == 3'd6) begin m_pol = d[0]; m_pp = d[1]; end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(a, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic pulse(input logic [3:0] t, input logic [3:0] r, input logic [3:0] s);
        tx_evt = t; rx_evt = r; sys_evt = s;
        tick();
        tx_evt = '0; rx_evt = '0; sys_evt = '0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_req = m;
        tick();
    endtask

    // Expected pin from the modelled configuration
    task automatic chk_pin(input bit active, input string req);
        bit exp_o, exp_oe;
        if (m_pp) begin exp_o = active ? m_pol : !m_pol; exp_oe = 1'b1; end
        else      begin exp_o = m_pol; exp_oe = active; end
        check(irq == exp_o && irq_oe == exp_oe, req, {irq, irq_oe}, {exp_o, exp_oe});
    endtask

    task automatic t_reset();
        check(irq == 1'b0 && irq_oe == 1'b0, "R11 pin", {irq, irq_oe}, 0);
        rd_chk(3'd0, 8'h00, "R11 tx enable");
        rd_chk(3'd5, 8'h00, "R11 sys status");
        rd_chk(3'd6, 8'h00, "R11 cfg");
    endtask

    task automatic t_enables();
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'h0F, "R4 tx enable width");
        wr(3'd1, 8'h0A);
        rd_chk(3'd1, 8'h0A, "R4 rx enable");
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_poll_disabled();
        pulse(4'h4, 4'h0, 4'h0);
        tick();
        chk_pin(1'b0, "R1 disabled no pin");
        rd_chk(3'd3, 8'h04, "R1 status latched");
        rd_chk(3'd3, 8'h00, "R2 cleared by read");
    endtask

    task automatic t_read_collision();
        logic [7:0] d;
        pulse(4'h0, 4'h1, 4'h0);
        rx_evt = 4'h1;
        rd(3'd4, d);
        rx_evt = 4'h0;
        check(d == 8'h01, "R2 read data", d, 8'h01);
        rd_chk(3'd4, 8'h01, "R2 event wins over clear");
        rd_chk(3'd4, 8'h00, "R2 later clear");
    endtask

    task automatic t_status_write();
        pulse(4'h0, 4'h0, 4'h2);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'hFF);
        rd_chk(3'd5, 8'h02, "R3 write no clear");
        rd_chk(3'd4, 8'h00, "R3 write no set");
    endtask

    task automatic t_pin_latency();
        wr(3'd2, 8'h02);
        pulse(4'h0, 4'h0, 4'h2);
        chk_pin(1'b0, "R5 not yet");
        tick();
        chk_pin(1'b1, "R5 asserted");
        rd_chk(3'd5, 8'h02, "R5 status");
        chk_pin(1'b1, "R5 held one edge");
        tick();
        chk_pin(1'b0, "R5 released");
        wr(3'd2, 8'h00);
    endtask

    task automatic t_mode_mask();
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h01);
        set_mode(2'b01);
        pulse(4'h0, 4'h1, 4'h0);
        tick();
        chk_pin(1'b0, "R6 tx mode blocks rx");
        set_mode(2'b00);
        tick();
        chk_pin(1'b1, "R6 idle unblocks pending rx");
        rd_chk(3'd4, 8'h01, "R1 masked status kept");
        set_mode(2'b10);
        pulse(4'h1, 4'h0, 4'h0);
        tick();
        chk_pin(1'b0, "R6 rx mode blocks tx");
        set_mode(2'b11);
        tick();
        chk_pin(1'b0, "R8 hold keeps rx mode");
        rd_chk(3'd0, 8'h01, "R7 tx enable kept");
        rd_chk(3'd1, 8'h01, "R7 rx enable kept");
        set_mode(2'b01);
        tick();
        chk_pin(1'b1, "R8 tx mode passes tx");
        rd_chk(3'd3, 8'h01, "R6 clear tx");
        wr(3'd2, 8'h08);
        pulse(4'h0, 4'h0, 4'h8);
        tick();
        chk_pin(1'b1, "R6 system never blocked");
        rd_chk(3'd5, 8'h08, "R6 clear sys");
        set_mode(2'b00);
    endtask

    task automatic t_pin_config();
        wr(3'd6, 8'h03);
        tick();
        chk_pin(1'b0, "R10 push-pull idle high-active");
        check(irq == 1'b0 && irq_oe == 1'b1, "R9 active-high idle", {irq, irq_oe}, 1);
        pulse(4'h0, 4'h0, 4'h8);
        tick();
        check(irq == 1'b1 && irq_oe == 1'b1, "R9 active-high assert", {irq, irq_oe}, 3);
        wr(3'd6, 8'h02);
        tick();
        check(irq == 1'b0 && irq_oe == 1'b1, "R9 active-low assert", {irq, irq_oe}, 1);
        wr(3'd6, 8'h01);
        tick();
        check(irq == 1'b1 && irq_oe == 1'b1, "R10 open-drain pulls", {irq, irq_oe}, 3);
        rd_chk(3'd6, 8'h01, "R9 cfg readback");
        rd_chk(3'd5, 8'h08, "R10 clear");
        tick();
        check(irq_oe == 1'b0, "R10 open-drain released", irq_oe, 0);
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enables();
        t_poll_disabled();
        t_read_collision();
        t_status_write();
        t_pin_latency();
        t_mode_mask();
        t_pin_config();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule